// File: doc/BRIEF.md
# Layered Min-Sum Check-Node Processing Element

This block is one processing element of a partially parallel decoder for quasi-cyclic LDPC codes that uses layered min-sum scheduling. Each cycle it may accept one parity-check row of the current layer. It receives the posterior LLRs of every column that takes part in that row. These values have already been aligned by a cyclic shifter outside the block, because the matrix is made of 360×360 circulant sub-blocks. Two clock edges later it returns the updated posteriors for the same row.

For each row, the element keeps the check-node state in compressed form in a small internal RAM. That state holds the smallest and second-smallest magnitude, the position of the smallest, one sign bit per edge, and the sign product. One generator rebuilds the previous check-to-variable messages from the stored state so they can be subtracted. A second generator builds the new messages from the state just computed, and these are added back. Every LLR is a 6-bit two's-complement value with saturating arithmetic. A codeword-start strobe clears all row state, so the first iteration subtracts zero.

Top module: `lms_row_engine`

## Requirements
- R1: After reset, out_valid is low and every row's stored state is zero, so the first visit to any row subtracts zero messages.
- R2: An input sampled with in_valid high at a clock edge yields out_valid high after the following edge, with out_row equal to that in_row. A cycle without in_valid yields out_valid low two edges later.
- R3: The variable-to-check value for edge i is q_i = posterior_i − old_i, saturated to the range −32..+31.
- R4: The magnitude of q_i is |q_i| clamped to 31. Its sign bit is 1 exactly when q_i is negative, so zero counts as positive.
- R5: The row's min1 is the smallest magnitude and its index is the lowest edge holding that value. min2 is the smallest magnitude among the remaining edges, so a tie gives min2 = min1.
- R6: The new check message for edge i has magnitude min2 if i is the min1 index and min1 otherwise. It is negative exactly when the XOR of the sign product and edge i's own sign bit is 1.
- R7: The output LLR for edge i is q_i plus the new message for edge i, saturated to −32..+31.
- R8: The old message subtracted on a row's next visit is rebuilt from the state stored on its previous visit, using the rule of R6.
- R9: When the same row is presented in two consecutive cycles, the second input uses the state computed for the first one.
- R10: A cycle with cw_start high clears every row's state. An input in that same cycle sees zero old messages, and the update of the row still in flight is discarded.
- R11: Edge i occupies bits [6i+5:6i] of in_llr and out_llr, and there are 6 edges per row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_start | input | 1 | Clears all row state at the start of a codeword |
| in_valid | input | 1 | A row is presented this cycle |
| in_row | input | 4 | Local row address (below ROWS) |
| in_llr | input | 36 | Shifted posterior LLRs, 6 edges of 6 bits |
| out_valid | output | 1 | Updated row result is present |
| out_row | output | 4 | Row address of the result |
| out_llr | output | 36 | Updated posterior LLRs, 6 edges of 6 bits |

## Verification
Every result appears two clock edges after its input is sampled: one edge registers the subtracted values and the next registers the updated posteriors. The reference model computes each expected row in the cycle it drives the input. It holds that result in a two-slot delay line and compares it against the ports at the falling edge two cycles later, which also checks that out_valid stays low for idle slots. Because the model applies rows strictly in order, its expectations also cover the back-to-back forwarding case and the discarded in-flight write at a codeword start.

// File: rtl/lms_pkg.sv
package lms_pkg;
    localparam int LLR_W   = 6;
    localparam int EDGE_N  = 6;
    localparam int MAG_W   = LLR_W - 1;
    localparam int IDX_W   = $clog2(EDGE_N);
    localparam int VEC_W   = EDGE_N * LLR_W;

    typedef logic signed [LLR_W-1:0] llr_t;
    typedef logic [MAG_W-1:0]        mag_t;

    typedef struct packed {
        mag_t              min1;
        mag_t              min2;
        logic [IDX_W-1:0]  idx;
        logic [EDGE_N-1:0] sgn;
        logic              prod;
    } row_state_t;

    // Clamp a one-bit-wider sum into the LLR range.
    function automatic llr_t sat_wide(input logic signed [LLR_W:0] v);
        logic signed [LLR_W:0] hi;
        logic signed [LLR_W:0] lo;
        hi = {2'b00, {(LLR_W-1){1'b1}}};
        lo = {2'b11, {(LLR_W-1){1'b0}}};
        if (v > hi)      return {1'b0, {(LLR_W-1){1'b1}}};
        else if (v < lo) return {1'b1, {(LLR_W-1){1'b0}}};
        else             return v[LLR_W-1:0];
    endfunction

    function automatic llr_t add_sat(input llr_t a, input llr_t b);
        logic signed [LLR_W:0] s;
        s = $signed({a[LLR_W-1], a}) + $signed({b[LLR_W-1], b});
        return sat_wide(s);
    endfunction

    function automatic llr_t sub_sat(input llr_t a, input llr_t b);
        logic signed [LLR_W:0] s;
        s = $signed({a[LLR_W-1], a}) - $signed({b[LLR_W-1], b});
        return sat_wide(s);
    endfunction

    // Magnitude clamped to the symmetric range.
    function automatic mag_t mag_of(input llr_t v);
        logic [LLR_W-1:0] n;
        if (v[LLR_W-1]) begin
            n = ~v + 1'b1;
            if (n[LLR_W-1]) return '1;
            else            return n[MAG_W-1:0];
        end
        return v[MAG_W-1:0];
    endfunction

    function automatic llr_t apply_sign(input mag_t m, input logic s);
        llr_t t;
        t = {1'b0, m};
        return s ? -t : t;
    endfunction
endpackage

// File: rtl/lms_msg_gen.sv
module lms_msg_gen
    import lms_pkg::*;
(
    input  row_state_t       st,
    output logic [VEC_W-1:0] msg
);
    for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
        assign msg[g*LLR_W +: LLR_W] =
            apply_sign((st.idx == IDX_W'(g)) ? st.min2 : st.min1, st.prod ^ st.sgn[g]);
    end
endmodule

// File: rtl/lms_min_finder.sv
module lms_min_finder
    import lms_pkg::*;
(
    input  logic [VEC_W-1:0] q,
    output row_state_t       st
);
    mag_t m_cur;
    logic s_cur;

    always_comb begin
        st      = '0;
        st.min1 = '1;
        st.min2 = '1;
        m_cur   = '0;
        s_cur   = 1'b0;
        for (int i = 0; i < EDGE_N; i++) begin
            m_cur     = mag_of(q[i*LLR_W +: LLR_W]);
            s_cur     = q[i*LLR_W + LLR_W - 1];
            st.sgn[i] = s_cur;
            st.prod   = st.prod ^ s_cur;
            if (m_cur < st.min1) begin
                st.min2 = st.min1;
                st.min1 = m_cur;
                st.idx  = IDX_W'(i);
            end else if (m_cur < st.min2) begin
                st.min2 = m_cur;
            end
        end
    end
endmodule

// File: rtl/lms_state_ram.sv
module lms_state_ram
    import lms_pkg::*;
#(
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW-1:0] rd_addr,
    output row_state_t    rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  row_state_t    wr_data
);
    row_state_t mem_q [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (clr) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_data == '0)); // R10
endmodule

// File: rtl/lms_row_engine.sv
module lms_row_engine
    import lms_pkg::*;
#(
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_start,
    input  logic             in_valid,
    input  logic [AW-1:0]    in_row,
    input  logic [VEC_W-1:0] in_llr,
    output logic             out_valid,
    output logic [AW-1:0]    out_row,
    output logic [VEC_W-1:0] out_llr
);
    typedef struct packed {
        logic             a_vld;
        logic [AW-1:0]    a_row;
        logic [VEC_W-1:0] a_q;
        logic             o_vld;
        logic [AW-1:0]    o_row;
        logic [VEC_W-1:0] o_llr;
    } pipe_t;

    pipe_t            pipe_d, pipe_q;
    row_state_t       ram_rd, old_state, new_state;
    logic [VEC_W-1:0] old_msg, new_msg;
    logic             fwd_hit;

    lms_state_ram #(.ROWS(ROWS)) i_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cw_start),
        .rd_addr (in_row),
        .rd_data (ram_rd),
        .wr_en   (pipe_q.a_vld),
        .wr_addr (pipe_q.a_row),
        .wr_data (new_state)
    );

    lms_min_finder i_find (
        .q  (pipe_q.a_q),
        .st (new_state)
    );

    lms_msg_gen i_gen_old (
        .st  (old_state),
        .msg (old_msg)
    );

    lms_msg_gen i_gen_new (
        .st  (new_state),
        .msg (new_msg)
    );

    // Select the row state the incoming row must subtract.
    always_comb begin
        fwd_hit = pipe_q.a_vld && (pipe_q.a_row == in_row);
        if (cw_start)     old_state = '0;
        else if (fwd_hit) old_state = new_state;
        else              old_state = ram_rd;
    end

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.a_vld = in_valid;
        if (in_valid) begin
            pipe_d.a_row = in_row;
            for (int e = 0; e < EDGE_N; e++) begin
                pipe_d.a_q[e*LLR_W +: LLR_W] =
                    sub_sat(in_llr[e*LLR_W +: LLR_W], old_msg[e*LLR_W +: LLR_W]);
            end
        end
        pipe_d.o_vld = pipe_q.a_vld;
        if (pipe_q.a_vld) begin
            pipe_d.o_row = pipe_q.a_row;
            for (int e = 0; e < EDGE_N; e++) begin
                pipe_d.o_llr[e*LLR_W +: LLR_W] =
                    add_sat(pipe_q.a_q[e*LLR_W +: LLR_W], new_msg[e*LLR_W +: LLR_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.o_vld;
    assign out_row   = pipe_q.o_row;
    assign out_llr   = pipe_q.o_llr;

    AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R2
    AST_ROW_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_row == $past(in_row, 2))); // R2
    AST_MIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.a_vld |-> (new_state.min1 <= new_state.min2)); // R5
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.a_vld |-> (new_state.idx < IDX_W'(EDGE_N))); // R5
endmodule

// File: tb/test_lms_row_engine.sv
module test_lms_row_engine;
    import lms_pkg::*;

    localparam int ROWS = 16;
    localparam int AW   = 4;
    localparam int W    = LLR_W;
    localparam int E    = EDGE_N;
    localparam int MAXV = (1 << (W-1)) - 1;
    localparam int MINV = -(1 << (W-1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cw_start = 1'b0;
    logic             in_valid = 1'b0;
    logic [AW-1:0]    in_row = '0;
    logic [VEC_W-1:0] in_llr = '0;
    logic             out_valid;
    logic [AW-1:0]    out_row;
    logic [VEC_W-1:0] out_llr;

    lms_row_engine #(.ROWS(ROWS)) i_lms_row_engine (
        .clk(clk), .rst_n(rst_n), .cw_start(cw_start), .in_valid(in_valid),
        .in_row(in_row), .in_llr(in_llr), .out_valid(out_valid),
        .out_row(out_row), .out_llr(out_llr)
    );

    always #5 clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    string req = "R1";

    int m_min1 [ROWS];
    int m_min2 [ROWS];
    int m_idx  [ROWS];
    int m_prod [ROWS];
    int m_sgn  [ROWS][E];

    bit ev [2];
    int er [2];
    int eo [2][E];

    function automatic int clampi(input int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic int old_msg(input int row, input int e);
        int mag;
        mag = (e == m_idx[row]) ? m_min2[row] : m_min1[row];
        return ((m_prod[row] ^ m_sgn[row][e]) != 0) ? -mag : mag;
    endfunction

    task automatic clear_model();
        for (int r = 0; r < ROWS; r++) begin
            m_min1[r] = 0; m_min2[r] = 0; m_idx[r] = 0; m_prod[r] = 0;
            for (int e = 0; e < E; e++) m_sgn[r][e] = 0;
        end
    endtask

    // Behavioural row update, rows applied strictly in arrival order.
    task automatic model(input int row, input int p [E], output int o [E]);
        int q [E];
        int a [E];
        int s [E];
        int mn1, mn2, ix, pr, nm;
        for (int e = 0; e < E; e++) begin
            q[e] = clampi(p[e] - old_msg(row, e));
            a[e] = (q[e] < 0) ? -q[e] : q[e];
            if (a[e] > MAXV) a[e] = MAXV;
            s[e] = (q[e] < 0) ? 1 : 0;
        end
        mn1 = 1000; ix = 0; pr = 0;
        for (int e = 0; e < E; e++) begin
            if (a[e] < mn1) begin mn1 = a[e]; ix = e; end
            pr = pr ^ s[e];
        end
        mn2 = 1000;
        for (int e = 0; e < E; e++) if (e != ix && a[e] < mn2) mn2 = a[e];
        for (int e = 0; e < E; e++) begin
            nm = (e == ix) ? mn2 : mn1;
            if ((pr ^ s[e]) != 0) nm = -nm;
            o[e] = clampi(q[e] + nm);
            m_sgn[row][e] = s[e];
        end
        m_min1[row] = mn1; m_min2[row] = mn2; m_idx[row] = ix; m_prod[row] = pr;
    endtask

    task automatic check();
        int act;
        vectors++;
        if (out_valid !== ev[1]) begin
            miscompares++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", req, out_valid, ev[1]);
        end else if (ev[1]) begin
            if (out_row !== AW'(er[1])) begin
                miscompares++;
                $display("FAIL %s out_row actual=%0d expected=%0d", req, out_row, er[1]);
            end
            for (int e = 0; e < E; e++) begin
                act = int'($signed(out_llr[e*W +: W]));
                if (act != eo[1][e]) begin
                    miscompares++;
                    $display("FAIL %s row %0d edge %0d actual=%0d expected=%0d",
                             req, er[1], e, act, eo[1][e]);
                end
            end
        end
    endtask

    task automatic cycle(input bit v, input int row, input int p [E], input bit st);
        int o [E];
        @(negedge clk);
        check();
        ev[1] = ev[0]; er[1] = er[0]; eo[1] = eo[0];
        cw_start = st;
        in_valid = v;
        in_row   = AW'(row);
        for (int e = 0; e < E; e++) in_llr[e*W +: W] = p[e][W-1:0];
        if (st) clear_model();
        if (v) begin
            model(row, p, o);
            ev[0] = 1'b1; er[0] = row; eo[0] = o;
        end else begin
            ev[0] = 1'b0;
        end
    endtask

    task automatic fill_rand(output int p [E]);
        for (int e = 0; e < E; e++) p[e] = int'($urandom_range(63)) - 32;
    endtask

    task automatic fill_const(output int p [E], input int v);
        for (int e = 0; e < E; e++) p[e] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int p [E];
        clear_model();
        ev[0] = 0; ev[1] = 0; er[0] = 0; er[1] = 0;
        fill_const(p, 0);
        // R1: outputs quiet during and after reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) cycle(0, 0, p, 0);

        // R1 / R6: first visit of rows subtracts zero
        req = "R6";
        for (int r = 0; r < 4; r++) begin fill_rand(p); cycle(1, r, p, 0); end

        // R8: second visit rebuilds the old messages
        req = "R8";
        for (int r = 0; r < 4; r++) begin fill_rand(p); cycle(1, r, p, 0); end

        // R3 and R7: saturation on both sides
        req = "R7";
        fill_const(p, MAXV);  cycle(1, 5, p, 0);
        fill_const(p, MINV);  cycle(1, 6, p, 0);
        req = "R3";
        fill_const(p, MINV);  cycle(1, 5, p, 0);
        fill_const(p, MAXV);  cycle(1, 6, p, 0);

        // R5: equal minima, lowest index wins and min2 equals min1
        req = "R5";
        p = '{3, -3, 7, 3, 9, -10}; cycle(1, 7, p, 0);
        p = '{-12, 4, 4, 20, -4, 31}; cycle(1, 8, p, 0);

        // R4: zero magnitude counts as positive
        req = "R4";
        p = '{0, -1, 0, 5, -6, 2}; cycle(1, 9, p, 0);
        p = '{0, 0, 0, 0, 0, 0};   cycle(1, 9, p, 0);

        // R2: gaps between rows
        req = "R2";
        fill_const(p, 0); cycle(0, 0, p, 0);
        fill_rand(p); cycle(1, 10, p, 0);
        fill_const(p, 0); cycle(0, 0, p, 0); cycle(0, 0, p, 0);
        fill_rand(p); cycle(1, 11, p, 0);

        // R9: same row in consecutive cycles
        req = "R9";
        for (int k = 0; k < 5; k++) begin fill_rand(p); cycle(1, 12, p, 0); end
        fill_rand(p); cycle(1, 2, p, 0);
        fill_rand(p); cycle(1, 2, p, 0);

        // R10: codeword start with and without a row
        req = "R10";
        fill_rand(p); cycle(1, 3, p, 1);
        fill_rand(p); cycle(1, 3, p, 0);
        fill_rand(p); cycle(1, 1, p, 0);
        fill_rand(p); cycle(0, 0, p, 1);
        fill_rand(p); cycle(1, 1, p, 0);
        fill_rand(p); cycle(1, 0, p, 0);

        // R11: distinct per-edge values across all rows
        req = "R11";
        for (int r = 0; r < ROWS; r++) begin
            for (int e = 0; e < E; e++) p[e] = ((r * 7 + e * 11) % 64) - 32;
            cycle(1, r, p, 0);
        end
        req = "R8";
        for (int k = 0; k < 300; k++) begin
            fill_rand(p);
            cycle(($urandom_range(3) != 0), int'($urandom_range(ROWS-1)), p,
                  ($urandom_range(40) == 0));
        end

        req = "R2";
        fill_const(p, 0);
        repeat (3) cycle(0, 0, p, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule